// File: doc/BRIEF.md
# Four-Channel Interleaved I/Q Output Port

This block merges complex samples from four independent sources onto one parallel output bus. Each source offers an (I, Q) pair whenever it has one. The pair waits in a single-entry holding register for that source. When any enabled source has a sample waiting, the port raises a request line. After one lead-in cycle it drives the waiting pairs one source at a time. Each pair goes out as the I word and then the Q word. A channel index and an I/Q flag travel alongside every word on the bus.

The receiver paces the transfer with an acknowledge input. A word counts as delivered only in a cycle where the request, the acknowledge and the word-valid output are all high. If the acknowledge drops, the bus holds its current word. When several sources are waiting at once, the lowest-numbered one goes first. A newer sample from a source replaces that source's unread sample and leaves the other sources untouched. A per-source enable mask chooses which sources take part.

Top module: `iq_port_mux`

## Requirements
- R1: Each sample leaves as two full-width words: first the I word with `port_isq` = 0, then the Q word with `port_isq` = 1. With `port_ack` held high, the two words are on consecutive clocks.
- R2: When a sample is posted (`smp_valid` high at a clock edge) to an idle port, `port_req` rises after the next edge, so two edges after the post. The first data word is valid one clock after `port_req` rises. `port_vld` is high only while `port_req` and `port_ack` are both high.
- R3: Sources that are waiting together are served in ascending index order, source 0 first. The choice is made again after every Q word.
- R4: A source's unread sample is replaced by a newer sample from the same source. The sample of any other source is not affected. A pair that has already started on the bus is not altered.
- R5: `port_chan` carries, as a binary number from 0 to 3, the index of the source of the word on the bus.
- R6: A sample posted while its `chan_en` bit is low is discarded and never appears. Clearing an enable bit also discards that source's waiting sample.
- R7: When all four sources are waiting, `port_req` is high for exactly 9 clocks: one lead-in clock followed by 8 data words.
- R8: `port_req` stays high without a gap for as long as any enabled source has a sample waiting when a Q word completes. A source that fills during a burst is served with no further lead-in. `port_req` drops in the clock after the final Q word.
- R9: While `port_ack` is low during a data word, `port_vld` is low and `port_data`, `port_chan` and `port_isq` hold their values. The I and Q words of one source are never separated by another source's word.
- R10: Synchronous reset clears `port_req`, `port_vld` and every waiting sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | NUM_CH | Per-source strobe: post a new I/Q pair |
| smp_i | input | NUM_CH*WORD_W | I words, source c at bits c*WORD_W upward |
| smp_q | input | NUM_CH*WORD_W | Q words, same packing as smp_i |
| chan_en | input | NUM_CH | Per-source enable mask |
| port_ack | input | 1 | Receiver acknowledge; low stalls the bus |
| port_req | output | 1 | Port has data to send or is sending |
| port_vld | output | 1 | The word on the bus is delivered this clock |
| port_data | output | WORD_W | I or Q word |
| port_chan | output | CHW | Source index of the current word |
| port_isq | output | 1 | 0 for the I word, 1 for the Q word |

## Verification
The hardest situation to reach is a stall that lands on the Q word while a sample from the same source arrives and a lower-priority source is already waiting. In that case the held Q word must not change, and the fresh sample must win the next slot. The stimulus posts sources 0 and 3, stalls both the I and the Q word of source 0, and reposts source 0 during the Q stall. It then checks every bus cycle against the expected sequence. Further directed cases cover these situations:
- a second sample that overwrites an unread one while the lead-in cycle runs;
- a source that fills in the middle of a burst;
- an enable bit cleared while a sample is waiting.

// File: rtl/iqp_pkg.sv
package iqp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LEAD   = 2'd1,
        ST_WORD_I = 2'd2,
        ST_WORD_Q = 2'd3
    } port_st_e;

    // index of the lowest set bit (0 if none)
    function automatic int unsigned lowest_set(input logic [31:0] m);
        lowest_set = 0;
        for (int b = 31; b >= 0; b--) begin
            if (m[b]) lowest_set = b;
        end
    endfunction

endpackage

// File: rtl/iqp_hold_bank.sv
module iqp_hold_bank #(
    parameter int NCH = 4,
    parameter int DW  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NCH-1:0]    ld,
    input  logic [NCH-1:0]    en,
    input  logic [NCH-1:0]    take,
    input  logic [NCH*DW-1:0] din_i,
    input  logic [NCH*DW-1:0] din_q,
    output logic [NCH-1:0]    pend,
    output logic [NCH*DW-1:0] hold_i,
    output logic [NCH*DW-1:0] hold_q
);

    for (genvar c = 0; c < NCH; c++) begin : g_slot
        // flag: a new sample beats a take in the same cycle
        always_ff @(posedge clk) begin
            if (rst)            pend[c] <= 1'b0;
            else if (!en[c])    pend[c] <= 1'b0;
            else if (ld[c])     pend[c] <= 1'b1;
            else if (take[c])   pend[c] <= 1'b0;
        end

        always_ff @(posedge clk) begin
            if (ld[c] && en[c]) begin
                hold_i[c*DW +: DW] <= din_i[c*DW +: DW];
                hold_q[c*DW +: DW] <= din_q[c*DW +: DW];
            end
        end

        // R4
        load_keeps_chk: assert property (@(posedge clk) disable iff (rst)
            (ld[c] && en[c]) |=> (pend[c] && hold_i[c*DW +: DW] == $past(din_i[c*DW +: DW])));

        // R6
        disabled_empty_chk: assert property (@(posedge clk) disable iff (rst)
            !en[c] |=> !pend[c]);
    end

endmodule

// File: rtl/iqp_seq.sv
module iqp_seq #(
    parameter int NCH = 4,
    parameter int DW  = 16,
    localparam int CW = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NCH-1:0]    pend_m,
    input  logic [NCH*DW-1:0] hold_i,
    input  logic [NCH*DW-1:0] hold_q,
    input  logic              ack,
    output logic [NCH-1:0]    take,
    output logic              req,
    output logic              vld,
    output logic [DW-1:0]     data,
    output logic [CW-1:0]     chan,
    output logic              isq
);
    import iqp_pkg::*;

    port_st_e       st, st_n;
    logic           any;
    logic           cap;
    logic [CW-1:0]  sel;
    logic [DW-1:0]  oi, oq;
    logic [CW-1:0]  ochan;

    assign any = |pend_m;
    assign sel = CW'(lowest_set(32'(pend_m)));
    assign cap = any && ((st == ST_LEAD) || (st == ST_WORD_Q && ack));
    assign take = cap ? (NCH'(1) << sel) : '0;

    always_comb begin
        st_n = st;
        unique case (st)
            ST_IDLE:   if (any) st_n = ST_LEAD;
            ST_LEAD:   st_n = any ? ST_WORD_I : ST_IDLE;
            ST_WORD_I: if (ack) st_n = ST_WORD_Q;
            ST_WORD_Q: if (ack) st_n = any ? ST_WORD_I : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st <= ST_IDLE;
        else     st <= st_n;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            oi    <= '0;
            oq    <= '0;
            ochan <= '0;
        end else if (cap) begin
            oi    <= hold_i[sel*DW +: DW];
            oq    <= hold_q[sel*DW +: DW];
            ochan <= sel;
        end
    end

    assign req  = (st != ST_IDLE);
    assign isq  = (st == ST_WORD_Q);
    assign vld  = ((st == ST_WORD_I) || (st == ST_WORD_Q)) && ack;
    assign data = isq ? oq : oi;
    assign chan = ochan;

    // R2
    vld_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
        vld |-> (req && ack));

    // R1
    q_follows_i_chk: assert property (@(posedge clk) disable iff (rst)
        (vld && !isq) |=> (isq && $stable(chan)));

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (req && !ack && (st == ST_WORD_I || st == ST_WORD_Q))
            |=> ($stable(data) && $stable(chan) && $stable(isq)));

    // R8
    burst_join_chk: assert property (@(posedge clk) disable iff (rst)
        (vld && isq && any) |=> (req && !isq));

endmodule

// File: rtl/iq_port_mux.sv
module iq_port_mux #(
    parameter int NUM_CH = 4,
    parameter int WORD_W = 16,
    localparam int CHW = $clog2(NUM_CH)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_CH-1:0]        smp_valid,
    input  logic [NUM_CH*WORD_W-1:0] smp_i,
    input  logic [NUM_CH*WORD_W-1:0] smp_q,
    input  logic [NUM_CH-1:0]        chan_en,
    input  logic                     port_ack,
    output logic                     port_req,
    output logic                     port_vld,
    output logic [WORD_W-1:0]        port_data,
    output logic [CHW-1:0]           port_chan,
    output logic                     port_isq
);

    logic [NUM_CH-1:0]        pend, pend_m, take;
    logic [NUM_CH*WORD_W-1:0] hold_i, hold_q;

    assign pend_m = pend & chan_en;

    iqp_hold_bank #(.NCH(NUM_CH), .DW(WORD_W)) u_bank (
        .clk    (clk),
        .rst    (rst),
        .ld     (smp_valid),
        .en     (chan_en),
        .take   (take),
        .din_i  (smp_i),
        .din_q  (smp_q),
        .pend   (pend),
        .hold_i (hold_i),
        .hold_q (hold_q)
    );

    iqp_seq #(.NCH(NUM_CH), .DW(WORD_W)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .pend_m (pend_m),
        .hold_i (hold_i),
        .hold_q (hold_q),
        .ack    (port_ack),
        .take   (take),
        .req    (port_req),
        .vld    (port_vld),
        .data   (port_data),
        .chan   (port_chan),
        .isq    (port_isq)
    );

    // R10
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!port_req && !port_vld));

endmodule

// File: tb/sim_iq_port_mux.sv
module sim_iq_port_mux;

    localparam int NCH = 4;
    localparam int DW  = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NCH-1:0]    smp_valid = '0;
    logic [NCH*DW-1:0] smp_i = '0;
    logic [NCH*DW-1:0] smp_q = '0;
    logic [NCH-1:0]    chan_en = '1;
    logic              port_ack = 1'b1;
    logic              port_req, port_vld, port_isq;
    logic [DW-1:0]     port_data;
    logic [1:0]        port_chan;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    iq_port_mux #(.NUM_CH(NCH), .WORD_W(DW)) u0 (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_i(smp_i),
        .smp_q(smp_q), .chan_en(chan_en), .port_ack(port_ack),
        .port_req(port_req), .port_vld(port_vld), .port_data(port_data),
        .port_chan(port_chan), .port_isq(port_isq)
    );

    always #5 clk = ~clk;

    // {enable mask, post mask}
    localparam logic [7:0] VEC [6] = '{8'hFF, 8'hF5, 8'hAF, 8'hF8, 8'h0F, 8'h63};

    function automatic logic [15:0] mk_i(int c, int v);
        return 16'((c + 1) * 4096 + v);
    endfunction
    function automatic logic [15:0] mk_q(int c, int v);
        return 16'(49152 + c * 256 + v);
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic nxt;
        @(negedge clk);
        smp_valid = '0;
    endtask

    task automatic post(input int c, input logic [15:0] i, input logic [15:0] q);
        smp_valid[c] = 1'b1;
        smp_i[c*DW +: DW] = i;
        smp_q[c*DW +: DW] = q;
    endtask

    task automatic expw(input string tag, input bit v, input int c,
                        input bit q, input logic [15:0] d);
        check(port_req == 1'b1, {tag, " req"}, 32'(port_req), 1);
        check(port_vld == v, {tag, " vld"}, 32'(port_vld), 32'(v));
        check(port_chan == 2'(c), {tag, " R5 chan"}, 32'(port_chan), 32'(c));
        check(port_isq == q, {tag, " isq"}, 32'(port_isq), 32'(q));
        check(port_data == d, {tag, " data"}, 32'(port_data), 32'(d));
    endtask

    task automatic expidle(input string tag);
        check(!port_req && !port_vld, tag, 32'({port_req, port_vld}), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int nw, rq_n, rq_first, fw, n;
        logic [1:0]  wc [8];
        logic        wq [8];
        logic [15:0] wd [8];
        int          ec [4];

        // R10: reset state
        repeat (3) nxt;
        #1 expidle("R10 reset");
        nxt; rst = 1'b0;
        #1 expidle("R10 after release");

        // vector table, ack held high
        for (int v = 0; v < 6; v++) begin
            nxt;
            chan_en = VEC[v][7:4];
            for (int c = 0; c < NCH; c++)
                if (VEC[v][c]) post(c, mk_i(c, v), mk_q(c, v));
            #1;
            nw = 0; rq_n = 0; rq_first = -1; fw = -1;
            for (int k = 1; k <= 14; k++) begin
                nxt; #1;
                if (port_req) begin
                    rq_n++;
                    if (rq_first < 0) rq_first = k;
                end
                if (port_vld) begin
                    if (nw < 8) begin
                        wc[nw] = port_chan; wq[nw] = port_isq; wd[nw] = port_data;
                    end
                    if (fw < 0) fw = k;
                    nw++;
                end
            end
            n = 0;
            for (int c = 0; c < NCH; c++)
                if (VEC[v][c] && VEC[v][4+c]) begin ec[n] = c; n++; end
            check(nw == 2*n, "R1 R6 word count", 32'(nw), 32'(2*n));
            for (int j = 0; j < n && 2*j+1 < nw; j++) begin
                check(wc[2*j] == 2'(ec[j]) && wc[2*j+1] == 2'(ec[j]),
                      "R3 R5 order", 32'(wc[2*j]), 32'(ec[j]));
                check(!wq[2*j] && wq[2*j+1], "R1 I/Q flag",
                      32'({wq[2*j], wq[2*j+1]}), 1);
                check(wd[2*j] == mk_i(ec[j], v) && wd[2*j+1] == mk_q(ec[j], v),
                      "R1 data", 32'({wd[2*j], wd[2*j+1]}),
                      32'({mk_i(ec[j], v), mk_q(ec[j], v)}));
            end
            check(rq_n == (n > 0 ? 2*n + 1 : 0), "R7 R8 req span", 32'(rq_n),
                  32'(n > 0 ? 2*n + 1 : 0));
            if (n > 0) begin
                check(rq_first == 2, "R2 req rise", 32'(rq_first), 2);
                check(fw == 3, "R2 first word", 32'(fw), 3);
            end
        end
        chan_en = '1;

        // R4: overwrite during lead-in, other source kept
        nxt; post(1, 16'h1A1A, 16'h1B1B); post(2, 16'h2A2A, 16'h2B2B); #1 expidle("R4 k0");
        nxt; post(2, 16'h2C2C, 16'h2D2D); #1 expidle("R4 k1");
        nxt; #1 check(port_req && !port_vld, "R2 lead-in", 32'({port_req, port_vld}), 2);
        nxt; #1 expw("R4 k3", 1, 1, 0, 16'h1A1A);
        nxt; #1 expw("R4 k4", 1, 1, 1, 16'h1B1B);
        nxt; #1 expw("R4 k5", 1, 2, 0, 16'h2C2C);
        nxt; #1 expw("R4 k6", 1, 2, 1, 16'h2D2D);
        nxt; #1 expidle("R4 single pair");

        // R9 stall with repost; R3 re-evaluation after Q
        nxt; post(0, 16'h0101, 16'h0202); post(3, 16'h3131, 16'h3232); #1;
        nxt; #1;
        nxt; #1;
        nxt; port_ack = 1'b0; #1 expw("R9 k3", 0, 0, 0, 16'h0101);
        nxt; port_ack = 1'b1; #1 expw("R9 k4", 1, 0, 0, 16'h0101);
        nxt; port_ack = 1'b0; post(0, 16'h0505, 16'h0606); #1 expw("R9 k5", 0, 0, 1, 16'h0202);
        nxt; #1 expw("R9 k6", 0, 0, 1, 16'h0202);
        nxt; port_ack = 1'b1; #1 expw("R9 k7", 1, 0, 1, 16'h0202);
        nxt; #1 expw("R3 k8", 1, 0, 0, 16'h0505);
        nxt; #1 expw("R3 k9", 1, 0, 1, 16'h0606);
        nxt; #1 expw("R3 k10", 1, 3, 0, 16'h3131);
        nxt; #1 expw("R3 k11", 1, 3, 1, 16'h3232);
        nxt; #1 expidle("R8 drop after last Q");

        // R8: source joins mid-burst with no lead-in
        nxt; post(2, 16'h2E2E, 16'h2F2F); #1;
        nxt; #1;
        nxt; #1;
        nxt; post(1, 16'h1E1E, 16'h1F1F); #1 expw("R8 k3", 1, 2, 0, 16'h2E2E);
        nxt; #1 expw("R8 k4", 1, 2, 1, 16'h2F2F);
        nxt; #1 expw("R8 k5", 1, 1, 0, 16'h1E1E);
        nxt; #1 expw("R8 k6", 1, 1, 1, 16'h1F1F);
        nxt; #1 expidle("R8 end");

        // R6: disabled post dropped; enable cleared while waiting
        nxt; chan_en = 4'b1011; post(2, 16'h7777, 16'h8888); #1;
        for (int k = 0; k < 4; k++) begin nxt; #1 expidle("R6 disabled post"); end
        nxt; chan_en = '1; #1;
        for (int k = 0; k < 3; k++) begin nxt; #1 expidle("R6 not revived"); end
        nxt; post(1, 16'h9999, 16'hAAAA); #1;
        nxt; chan_en = 4'b1101; #1;
        nxt; #1 expidle("R6 cleared enable");
        nxt; chan_en = '1; #1;
        for (int k = 0; k < 3; k++) begin nxt; #1 expidle("R6 discarded"); end

        // R10: reset mid-burst clears waiting samples
        nxt; post(0, 16'h0C0C, 16'h0D0D); post(1, 16'h1C1C, 16'h1D1D); #1;
        nxt; #1; nxt; #1; nxt; #1;
        nxt; rst = 1'b1; #1;
        nxt; rst = 1'b0; #1 expidle("R10 mid-burst reset");
        for (int k = 0; k < 4; k++) begin nxt; #1 expidle("R10 nothing waiting"); end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule